// File: doc/BRIEF.md
# Infrared Port Carrier Modulator

This block sits between a UART and the two pads of an infrared link. On the transmit side it takes the UART serial line and can gate it with a carrier of about 38 kHz. The carrier is built from a free-running counter whose length comes from the system clock frequency. A two-bit field sets the fraction of each carrier period during which the pad is driven low. A polarity bit can complement the result before it reaches the LED pad. While the brownout flag is raised, the carrier is suppressed and the UART level passes through unmodulated.

On the receive side the photodetector pad can be complemented before it feeds the UART receiver. Either pad can be handed to another use when the optical link is idle. The transmit pad can carry a general digital output, a pulse output or a fixed idle level. The receive pad can be released to act as a general digital input, and the UART receive line is then parked at its idle level.

Top module: `irport_mod`

## Requirements
- R1: Reset clears the carrier counter, so the first clock cycle after reset release lies in the low portion of the carrier (tx_pad_o low when sending a space with modulation on, non-inverted, tx_sel_i=00).
- R2: The carrier period is CLK_HZ/CARRIER_HZ clock cycles (129 at the defaults), measured between successive falling edges of tx_pad_o.
- R3: duty_sel_i sets the number of low cycles per carrier period to PERIOD>>(duty_sel_i+1): 00 gives 50 %, 01 gives 25 %, 10 gives 12.5 % and 11 gives 6.25 %.
- R4: With tx_sel_i=00 and no inversion, a UART mark (uart_tx_i=1) drives tx_pad_o high in every cycle, and a space with modulation off drives it low.
- R5: While brownout_i is 1, modulation is off even with mod_en_i=1: a space holds tx_pad_o low for the whole period.
- R6: tx_inv_i=1 makes tx_pad_o the exact complement of the non-inverted UART path, modulated or not, so an inverted modulated space is high for exactly PERIOD>>(duty_sel_i+1) cycles per period.
- R7: tx_sel_i selects the transmit pad source: 00 UART path, 01 dio_out_i, 10 pulse_i, 11 constant high; tx_inv_i has no effect on codes 01, 10 and 11.
- R8: With rx_dis_i=0, uart_rx_o equals rx_pad_i XOR rx_inv_i and dio_in_o is 0.
- R9: With rx_dis_i=1, uart_rx_o is held at 1 whatever rx_pad_i and rx_inv_i are, and dio_in_o equals rx_pad_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| brownout_i | input | 1 | Main power absent; suppresses the carrier |
| mod_en_i | input | 1 | Carrier modulation enable |
| duty_sel_i | input | 2 | Carrier low-fraction select |
| tx_inv_i | input | 1 | Complement the UART transmit path |
| rx_inv_i | input | 1 | Complement the receive pad |
| tx_sel_i | input | 2 | Transmit pad source select |
| rx_dis_i | input | 1 | Release receive pad to general input |
| uart_tx_i | input | 1 | UART serial transmit data, 1 = mark |
| dio_out_i | input | 1 | General digital output value |
| pulse_i | input | 1 | Pulse output source |
| rx_pad_i | input | 1 | Photodetector pad |
| tx_pad_o | output | 1 | LED pad drive |
| uart_rx_o | output | 1 | Conditioned UART receive data |
| dio_in_o | output | 1 | General digital input value |

## Verification
The hardest case to reach is the duty and period of the carrier. Its phase is set only by the free-running counter, and no port exposes that counter. The bench holds a modulated space and samples tx_pad_o over a whole period, counting low cycles for each duty code, so the result does not depend on phase. It then measures the spacing between falling edges for the period. The same window is run again under brownout and under inversion, to show the carrier is suppressed in the first and complemented exactly in the second.

// File: rtl/irport_pkg.sv
package irport_pkg;
  typedef enum logic [1:0] {
    TXS_UART  = 2'b00,
    TXS_DIO   = 2'b01,
    TXS_PULSE = 2'b10,
    TXS_IDLE  = 2'b11
  } tx_sel_e;

  typedef enum logic [1:0] {
    DUTY_HALF   = 2'b00,
    DUTY_QUART  = 2'b01,
    DUTY_EIGHTH = 2'b10,
    DUTY_SIXTNTH = 2'b11
  } duty_e;
endpackage

// File: rtl/irport_carrier.sv
module irport_carrier #(
  parameter int PERIOD = 129,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    duty_i,
  output logic [CW-1:0] cnt_o,
  output logic          low_o
);
  import irport_pkg::*;

  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] LOW_1_2 = CW'(PERIOD >> 1);
  localparam logic [CW-1:0] LOW_1_4 = CW'(PERIOD >> 2);
  localparam logic [CW-1:0] LOW_1_8 = CW'(PERIOD >> 3);
  localparam logic [CW-1:0] LOW_116 = CW'(PERIOD >> 4);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (duty_e'(duty_i))
      DUTY_HALF:   low_lim = LOW_1_2;
      DUTY_QUART:  low_lim = LOW_1_4;
      DUTY_EIGHTH: low_lim = LOW_1_8;
      default:     low_lim = LOW_116;
    endcase
  end

  assign cnt_o = cnt_q;
  assign low_o = (cnt_q < low_lim);
endmodule

// File: rtl/irport_tx_path.sv
module irport_tx_path (
  input  logic       mod_act_i,
  input  logic       carrier_low_i,
  input  logic       uart_tx_i,
  input  logic       tx_inv_i,
  input  logic [1:0] tx_sel_i,
  input  logic       dio_out_i,
  input  logic       pulse_i,
  output logic       tx_o
);
  import irport_pkg::*;

  logic uart_shaped;

  // mark passes as idle high; a space pulses with the carrier when active
  assign uart_shaped = (uart_tx_i | (mod_act_i & ~carrier_low_i)) ^ tx_inv_i;

  always_comb begin
    unique case (tx_sel_e'(tx_sel_i))
      TXS_UART:  tx_o = uart_shaped;
      TXS_DIO:   tx_o = dio_out_i;
      TXS_PULSE: tx_o = pulse_i;
      default:   tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/irport_rx_path.sv
module irport_rx_path (
  input  logic rx_pad_i,
  input  logic rx_inv_i,
  input  logic rx_dis_i,
  output logic uart_rx_o,
  output logic dio_in_o
);
  assign uart_rx_o = rx_dis_i ? 1'b1 : (rx_pad_i ^ rx_inv_i);
  assign dio_in_o  = rx_dis_i & rx_pad_i;
endmodule

// File: rtl/irport_mod.sv
module irport_mod #(
  parameter int CLK_HZ     = 4_915_200,
  parameter int CARRIER_HZ = 38_000,
  parameter int PERIOD     = CLK_HZ / CARRIER_HZ,
  parameter int CW         = $clog2(PERIOD)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brownout_i,
  input  logic       mod_en_i,
  input  logic [1:0] duty_sel_i,
  input  logic       tx_inv_i,
  input  logic       rx_inv_i,
  input  logic [1:0] tx_sel_i,
  input  logic       rx_dis_i,
  input  logic       uart_tx_i,
  input  logic       dio_out_i,
  input  logic       pulse_i,
  input  logic       rx_pad_i,
  output logic       tx_pad_o,
  output logic       uart_rx_o,
  output logic       dio_in_o
);
  logic [CW-1:0] carrier_cnt;
  logic          carrier_low;
  logic          mod_act;

  assign mod_act = mod_en_i & ~brownout_i;

  irport_carrier #(.PERIOD(PERIOD), .CW(CW)) u_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .duty_i (duty_sel_i),
    .cnt_o  (carrier_cnt),
    .low_o  (carrier_low)
  );

  irport_tx_path u_tx (
    .mod_act_i     (mod_act),
    .carrier_low_i (carrier_low),
    .uart_tx_i     (uart_tx_i),
    .tx_inv_i      (tx_inv_i),
    .tx_sel_i      (tx_sel_i),
    .dio_out_i     (dio_out_i),
    .pulse_i       (pulse_i),
    .tx_o          (tx_pad_o)
  );

  irport_rx_path u_rx (
    .rx_pad_i  (rx_pad_i),
    .rx_inv_i  (rx_inv_i),
    .rx_dis_i  (rx_dis_i),
    .uart_rx_o (uart_rx_o),
    .dio_in_o  (dio_in_o)
  );
endmodule

// File: rtl/irport_mod_chk.sv
module irport_mod_chk #(
  parameter int PERIOD = 129,
  parameter int CW     = $clog2(PERIOD)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          brownout_i,
  input logic          tx_inv_i,
  input logic          rx_inv_i,
  input logic [1:0]    tx_sel_i,
  input logic          rx_dis_i,
  input logic          uart_tx_i,
  input logic          dio_out_i,
  input logic          rx_pad_i,
  input logic          tx_pad_o,
  input logic          uart_rx_o,
  input logic          dio_in_o,
  input logic [CW-1:0] carrier_cnt
);
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_cnt < CW'(PERIOD));

  assert_cnt_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_cnt == CW'(PERIOD - 1) |=> carrier_cnt == '0);

  assert_mark_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sel_i == 2'b00 && uart_tx_i && !tx_inv_i) |-> tx_pad_o);

  assert_brownout_flat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brownout_i && tx_sel_i == 2'b00) |-> tx_pad_o == (uart_tx_i ^ tx_inv_i));

  assert_dio_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sel_i == 2'b01) |-> tx_pad_o == dio_out_i);

  assert_rx_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dis_i |-> (uart_rx_o == (rx_pad_i ^ rx_inv_i)) && !dio_in_o);

  assert_rx_park_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_i |-> uart_rx_o && (dio_in_o == rx_pad_i));
endmodule

bind irport_mod irport_mod_chk #(.PERIOD(PERIOD), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .brownout_i  (brownout_i),
  .tx_inv_i    (tx_inv_i),
  .rx_inv_i    (rx_inv_i),
  .tx_sel_i    (tx_sel_i),
  .rx_dis_i    (rx_dis_i),
  .uart_tx_i   (uart_tx_i),
  .dio_out_i   (dio_out_i),
  .rx_pad_i    (rx_pad_i),
  .tx_pad_o    (tx_pad_o),
  .uart_rx_o   (uart_rx_o),
  .dio_in_o    (dio_in_o),
  .carrier_cnt (carrier_cnt)
);

// File: tb/tb_irport_mod.sv
module tb_irport_mod;
  localparam int PERIOD = 4_915_200 / 38_000;
  localparam int NVEC   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brownout = 0, mod_en = 0, tx_inv = 0, rx_inv = 0, rx_dis = 0;
  logic uart_tx = 1, dio_out = 0, pulse = 0, rx_pad = 1;
  logic [1:0] duty_sel = 2'b00, tx_sel = 2'b00;
  logic tx_pad, uart_rx, dio_in;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irport_mod dut (
    .clk_i(clk), .rst_ni(rst_n), .brownout_i(brownout), .mod_en_i(mod_en),
    .duty_sel_i(duty_sel), .tx_inv_i(tx_inv), .rx_inv_i(rx_inv),
    .tx_sel_i(tx_sel), .rx_dis_i(rx_dis), .uart_tx_i(uart_tx),
    .dio_out_i(dio_out), .pulse_i(pulse), .rx_pad_i(rx_pad),
    .tx_pad_o(tx_pad), .uart_rx_o(uart_rx), .dio_in_o(dio_in)
  );

  // [15]mod [14]bo [13]txinv [12:11]sel [10]utx [9]dio [8]pulse
  // [7]rxpad [6]rxinv [5]rxdis [2]exp_tx [1]exp_rx [0]exp_din
  localparam logic [15:0] VEC [NVEC] = '{
    16'b0000_0100_1000_0110,  // R4 mark, R8 pass
    16'b0000_0000_0000_0000,  // R4 space unmodulated
    16'b0010_0100_0100_0010,  // R6 R8 inverted
    16'b0010_0000_1100_0100,  // R6 R8 inverted
    16'b1000_0100_1000_0110,  // R4 mark with modulation on
    16'b1100_0000_0000_0000,  // R5 brownout space
    16'b1110_0000_0000_0100,  // R5 R6
    16'b0000_1010_0000_0100,  // R7 dio high
    16'b0010_1101_0000_0000,  // R7 dio low, inversion ignored
    16'b0001_0001_0000_0100,  // R7 pulse high
    16'b0011_0110_0000_0000,  // R7 pulse low, inversion ignored
    16'b1011_1000_0000_0100,  // R7 idle code
    16'b0000_0100_1110_0111,  // R9 parked, din follows pad
    16'b0000_0100_0010_0110,  // R9 din low
    16'b0000_0100_0110_0110   // R9 inversion ignored
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic count_low(output int lows);
    lows = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (!tx_pad) lows++;
    end
  endtask

  task automatic fall_spacing(output int span);
    logic prev;
    @(negedge clk);
    prev = tx_pad;
    forever begin
      @(negedge clk);
      if (prev && !tx_pad) break;
      prev = tx_pad;
    end
    span = 0;
    prev = tx_pad;
    forever begin
      @(negedge clk);
      span++;
      if (prev && !tx_pad) break;
      prev = tx_pad;
    end
  endtask

  initial begin
    #400_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int lows, span;
    // R1: space with 50 % modulation across reset release
    mod_en = 1; uart_tx = 0; duty_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first cycle low", tx_pad, 0);
    chk("R8 rx after reset", uart_rx, 1);

    // R3 duty table and R2 period
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      duty_sel = 2'(d);
      count_low(lows);
      chk($sformatf("R3 low cycles duty %0d", d), lows, PERIOD >> (d + 1));
    end
    duty_sel = 2'b00;
    fall_spacing(span);
    chk("R2 period duty 0", span, PERIOD);
    duty_sel = 2'b11;
    fall_spacing(span);
    chk("R2 period duty 3", span, PERIOD);

    // R6 inverted modulated space
    @(negedge clk);
    tx_inv = 1; duty_sel = 2'b01;
    count_low(lows);
    chk("R6 inverted high cycles", PERIOD - lows, PERIOD >> 2);

    // R5 brownout over a full period
    @(negedge clk);
    tx_inv = 0; brownout = 1;
    count_low(lows);
    chk("R5 brownout all low", lows, PERIOD);

    // R4 mark with modulation over a full period
    @(negedge clk);
    brownout = 0; uart_tx = 1;
    count_low(lows);
    chk("R4 mark never low", lows, 0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {mod_en, brownout, tx_inv, tx_sel, uart_tx, dio_out, pulse} = VEC[v][15:8];
      {rx_pad, rx_inv, rx_dis} = VEC[v][7:5];
      duty_sel = 2'b00;
      #1;
      chk($sformatf("R4-path vec %0d tx_pad", v), tx_pad, VEC[v][2]);
      chk($sformatf("R8 R9 vec %0d uart_rx", v), uart_rx, VEC[v][1]);
      chk($sformatf("R9 vec %0d dio_in", v), dio_in, VEC[v][0]);
    end

    // R7 idle code ignores pulse and dio
    @(negedge clk);
    tx_sel = 2'b11; tx_inv = 1; pulse = 1; dio_out = 0; uart_tx = 0;
    #1;
    chk("R7 idle code high", tx_pad, 1);

    // R1 reset asserted mid-period restarts low phase
    @(negedge clk);
    tx_sel = 2'b00; tx_inv = 0; mod_en = 1; brownout = 0; duty_sel = 2'b11;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    #1;
    chk("R1 restart in low phase", tx_pad, 0);

    summary();
    $finish;
  end
endmodule